// File: doc/BRIEF.md
# Machine-Mode CSR and Trap Unit

This block holds the control and status registers of a small 32-bit core that runs in two privilege levels, Machine and User. The decoder presents one register access per cycle: a 12-bit register address, a source value, an operation (write, set bits, clear bits) and a flag saying the source register is the zero register. The unit returns the old register value together with a write-enable for the destination register. Each access is checked against the current privilege and the register's read-only status. An access that fails either check becomes an illegal-instruction trap.

Traps come from two places: a failed register access or return, and an external exception request that carries its own cause code. On a trap the unit captures the faulting PC, the cause and the raw instruction word. It saves the old privilege and interrupt enable in the status register, switches to Machine privilege, and redirects fetch to the handler base in the same cycle. A machine-return request redirects fetch to the saved PC and drops privilege to the saved level. A free-running cycle counter of up to 64 bits can be read as two 32-bit halves.

Top module: `csr_trap_unit`

## Requirements
- R1: After reset the privilege output is Machine (2'b11), the status register reads 0, the trap cause reads 0, the trap vector reads `MTVEC_RESET` and the cycle counter holds `CYCLE_INIT`.
- R2: Operation codes are 2'b01 write, 2'b10 set bits (OR) and 2'b11 clear bits (AND with the inverted source). A legal access returns the register's old value on `rd_data` with `rd_we` high in the same cycle, and the new value is visible from the next cycle.
- R3: The status register (0x300) keeps only MIE (bit 3), MPIE (bit 7) and MPP (bits 12:11). Other bits read 0. A written MPP value other than 2'b11 is stored as 2'b00.
- R4: Address bits [9:8] give the lowest privilege allowed to access the register. An access from a lower privilege is an illegal-instruction trap. User mode may read the cycle counter but not any Machine register.
- R5: An address with bits [11:10] = 2'b11 is read-only. A write, or a set or clear with `csr_src_zero` low, traps as illegal and leaves the counter running unchanged. A set or clear with `csr_src_zero` high is a legal read.
- R6: Only 0x300, 0x304, 0x305, 0x340, 0x341, 0x342, 0x343 (trap value), 0xC00 (counter low half) and 0xC80 (counter high half) exist. Any other address, and operation code 2'b00, traps as illegal.
- R7: An illegal-instruction trap sets the trap cause to `ILLEGAL_CAUSE` (2) with bit 31 clear, the saved PC to `instr_pc` and the trap value to `instr_word`. It leaves the addressed register unchanged and keeps `rd_we` low.
- R8: On any trap, MPP takes the privilege the trap came from (3 or 0), MPIE takes the old MIE, MIE clears and the privilege becomes Machine from the next cycle.
- R9: The trap vector runs in direct mode only: its bits [1:0] read 0, and every trap raises `redirect_valid` with `redirect_pc` equal to the trap vector in the same cycle.
- R10: A machine return in Machine mode raises `redirect_valid` with `redirect_pc` equal to the saved PC. It then sets the privilege to MPP, MIE to MPIE, MPIE to 1 and MPP to 0. A machine return in User mode is an illegal-instruction trap.
- R11: The cycle counter advances by one on every clock after reset. Address 0xC00 reads its low 32 bits and 0xC80 its upper bits.
- R12: `exc_req` outranks `csr_req`, which outranks `mret_req`. A register access that arrives with an exception request has no effect and returns `rd_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_req | input | 1 | Register access valid this cycle |
| csr_op | input | 2 | Access operation code |
| csr_addr | input | 12 | Register address |
| csr_src | input | XLEN | Source operand |
| csr_src_zero | input | 1 | Source register is the zero register |
| mret_req | input | 1 | Machine-return request |
| exc_req | input | 1 | External exception request |
| exc_cause | input | CAUSE_W | Cause code for the external exception |
| instr_pc | input | XLEN | PC of the current instruction |
| instr_word | input | XLEN | Raw current instruction word |
| priv_o | output | 2 | Current privilege (3 Machine, 0 User) |
| rd_data | output | XLEN | Old value of the addressed register |
| rd_we | output | 1 | Destination register write-enable |
| redirect_valid | output | 1 | Fetch redirect this cycle |
| redirect_pc | output | XLEN | Redirect target |

## Verification
The bench builds the unit with XLEN 32 and a 64-bit counter. It sets `CYCLE_INIT` to 0x1_FFFF_FFF0, so the carry into the high half happens within a few dozen cycles and both halves can be compared against a model of the counter. It sets `MTVEC_RESET` to 0x100, so the reset value of the trap vector can be told apart from zero. With these values the bench walks a full trip from Machine to User mode and back. The trip covers a permission trap, a return attempted from User mode, and an external exception that collides with a register write.

// File: rtl/csr_trap_pkg.sv
`timescale 1ns/1ps
package csr_trap_pkg;
   typedef enum logic [1:0] {OP_NONE = 2'b00, OP_RW = 2'b01, OP_RS = 2'b10, OP_RC = 2'b11} csr_op_e;

   localparam logic [1:0] PRIV_U = 2'b00;
   localparam logic [1:0] PRIV_M = 2'b11;

   localparam int CSR_AW = 12;
   localparam int NCSR   = 9;

   // register slots
   localparam int IX_STATUS  = 0;
   localparam int IX_IEN     = 1;
   localparam int IX_TVEC    = 2;
   localparam int IX_SCRATCH = 3;
   localparam int IX_EPC     = 4;
   localparam int IX_CAUSE   = 5;
   localparam int IX_TVAL    = 6;
   localparam int IX_CYC_LO  = 7;
   localparam int IX_CYC_HI  = 8;

   localparam logic [CSR_AW-1:0] CSR_MAP [NCSR] = '{
      12'h300, 12'h304, 12'h305, 12'h340, 12'h341, 12'h342, 12'h343, 12'hC00, 12'hC80};

   // status register field positions
   localparam int ST_MIE  = 3;
   localparam int ST_MPIE = 7;
   localparam int ST_MPP  = 11;
endpackage

// File: rtl/csr_trap_decode.sv
`timescale 1ns/1ps
module csr_trap_decode
   import csr_trap_pkg::*;
(
   input  logic              csr_req,
   input  csr_op_e           op,
   input  logic [CSR_AW-1:0] addr,
   input  logic              src_zero,
   input  logic [1:0]        priv,
   output logic [NCSR-1:0]   sel,
   output logic              is_write,
   output logic              illegal
);
   logic no_reg, low_priv, ro_hit;

   for (genvar g = 0; g < NCSR; g++) begin : g_match
      assign sel[g] = (addr == CSR_MAP[g]);
   end

   assign is_write = (op == OP_RW) || (((op == OP_RS) || (op == OP_RC)) && !src_zero);
   assign no_reg   = ~|sel;
   assign low_priv = addr[9:8] > priv;
   assign ro_hit   = (addr[11:10] == 2'b11) && is_write;
   assign illegal  = csr_req && ((op == OP_NONE) || no_reg || low_priv || ro_hit);
endmodule

// File: rtl/csr_cycle_ctr.sv
`timescale 1ns/1ps
module csr_cycle_ctr #(
   parameter int                XLEN  = 32,
   parameter int                CNT_W = 64,
   parameter logic [CNT_W-1:0]  INIT  = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt_q,
   output logic [XLEN-1:0]  lo,
   output logic [XLEN-1:0]  hi
);
   if (CNT_W < XLEN || CNT_W > 2*XLEN) begin : g_bad_width
      $error("csr_cycle_ctr: CNT_W must lie in [XLEN, 2*XLEN]");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= INIT;
      else        cnt_q <= cnt_q + 1'b1;
   end

   assign lo = cnt_q[XLEN-1:0];

   if (CNT_W > XLEN) begin : g_split
      assign hi = XLEN'(cnt_q[CNT_W-1:XLEN]);
   end else begin : g_narrow
      assign hi = '0;
   end
endmodule

// File: rtl/csr_trap_unit.sv
`timescale 1ns/1ps
module csr_trap_unit
   import csr_trap_pkg::*;
#(
   parameter int                XLEN          = 32,
   parameter int                CNT_W         = 64,
   parameter int                CAUSE_W       = 5,
   parameter int                ILLEGAL_CAUSE = 2,
   parameter logic [CNT_W-1:0]  CYCLE_INIT    = '0,
   parameter logic [XLEN-1:0]   MTVEC_RESET   = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 csr_req,
   input  logic [1:0]           csr_op,
   input  logic [CSR_AW-1:0]    csr_addr,
   input  logic [XLEN-1:0]      csr_src,
   input  logic                 csr_src_zero,
   input  logic                 mret_req,
   input  logic                 exc_req,
   input  logic [CAUSE_W-1:0]   exc_cause,
   input  logic [XLEN-1:0]      instr_pc,
   input  logic [XLEN-1:0]      instr_word,
   output logic [1:0]           priv_o,
   output logic [XLEN-1:0]      rd_data,
   output logic                 rd_we,
   output logic                 redirect_valid,
   output logic [XLEN-1:0]      redirect_pc
);
   if (XLEN < ST_MPP + 2) begin : g_bad_xlen
      $error("csr_trap_unit: XLEN too small for the status fields");
   end
   if (CAUSE_W >= XLEN || ILLEGAL_CAUSE >= (1 << CAUSE_W)) begin : g_bad_cause
      $error("csr_trap_unit: cause width or illegal cause out of range");
   end

   localparam logic [CAUSE_W-1:0] ILL_CODE = CAUSE_W'(ILLEGAL_CAUSE);

   // architectural state
   logic [1:0]      priv_q;
   logic            st_mie, st_mpie;
   logic [1:0]      st_mpp;
   logic [XLEN-1:0] ien_q, tvec_q, scratch_q, epc_q, cause_q, tval_q;

   logic [CNT_W-1:0] cyc_full;
   logic [XLEN-1:0]  cyc_lo, cyc_hi;

   csr_cycle_ctr #(.XLEN(XLEN), .CNT_W(CNT_W), .INIT(CYCLE_INIT)) u_ctr (
      .clk(clk), .rst_n(rst_n), .cnt_q(cyc_full), .lo(cyc_lo), .hi(cyc_hi));

   csr_op_e         op_e;
   logic [NCSR-1:0] sel;
   logic            is_write, illegal;

   assign op_e = csr_op_e'(csr_op);

   csr_trap_decode u_dec (
      .csr_req(csr_req), .op(op_e), .addr(csr_addr), .src_zero(csr_src_zero),
      .priv(priv_q), .sel(sel), .is_write(is_write), .illegal(illegal));

   // read side
   logic [XLEN-1:0] status_val, old_val, new_val;
   logic [XLEN-1:0] reg_val [NCSR];

   always_comb begin
      status_val = '0;
      status_val[ST_MIE]             = st_mie;
      status_val[ST_MPIE]            = st_mpie;
      status_val[ST_MPP+1:ST_MPP]    = st_mpp;
      reg_val[IX_STATUS]  = status_val;
      reg_val[IX_IEN]     = ien_q;
      reg_val[IX_TVEC]    = tvec_q;
      reg_val[IX_SCRATCH] = scratch_q;
      reg_val[IX_EPC]     = epc_q;
      reg_val[IX_CAUSE]   = cause_q;
      reg_val[IX_TVAL]    = tval_q;
      reg_val[IX_CYC_LO]  = cyc_lo;
      reg_val[IX_CYC_HI]  = cyc_hi;
      old_val = '0;
      for (int i = 0; i < NCSR; i++) begin
         if (sel[i]) old_val = old_val | reg_val[i];
      end
      unique case (op_e)
         OP_RW:   new_val = csr_src;
         OP_RS:   new_val = old_val | csr_src;
         OP_RC:   new_val = old_val & ~csr_src;
         default: new_val = old_val;
      endcase
   end

   // arbitration: exception > register access > return
   logic csr_live, csr_ok, mret_live, mret_ok, trap;
   logic [CAUSE_W-1:0] trap_cause;

   assign csr_live   = csr_req && !exc_req;
   assign csr_ok     = csr_live && !illegal;
   assign mret_live  = mret_req && !exc_req && !csr_req;
   assign mret_ok    = mret_live && (priv_q == PRIV_M);
   assign trap       = exc_req || (csr_live && illegal) || (mret_live && (priv_q != PRIV_M));
   assign trap_cause = exc_req ? exc_cause : ILL_CODE;

   logic [NCSR-1:0] wr_sel;
   assign wr_sel = (csr_ok && is_write) ? sel : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         priv_q    <= PRIV_M;
         st_mie    <= 1'b0;
         st_mpie   <= 1'b0;
         st_mpp    <= PRIV_U;
         ien_q     <= '0;
         tvec_q    <= {MTVEC_RESET[XLEN-1:2], 2'b00};
         scratch_q <= '0;
         epc_q     <= '0;
         cause_q   <= '0;
         tval_q    <= '0;
      end else if (trap) begin
         epc_q   <= instr_pc;
         cause_q <= XLEN'(trap_cause);
         tval_q  <= instr_word;
         st_mpp  <= priv_q;
         st_mpie <= st_mie;
         st_mie  <= 1'b0;
         priv_q  <= PRIV_M;
      end else if (mret_ok) begin
         priv_q  <= st_mpp;
         st_mie  <= st_mpie;
         st_mpie <= 1'b1;
         st_mpp  <= PRIV_U;
      end else begin
         if (wr_sel[IX_STATUS]) begin
            st_mie  <= new_val[ST_MIE];
            st_mpie <= new_val[ST_MPIE];
            st_mpp  <= (new_val[ST_MPP+1:ST_MPP] == PRIV_M) ? PRIV_M : PRIV_U;
         end
         if (wr_sel[IX_IEN])     ien_q     <= new_val;
         if (wr_sel[IX_TVEC])    tvec_q    <= {new_val[XLEN-1:2], 2'b00};
         if (wr_sel[IX_SCRATCH]) scratch_q <= new_val;
         if (wr_sel[IX_EPC])     epc_q     <= new_val;
         if (wr_sel[IX_CAUSE])   cause_q   <= new_val;
         if (wr_sel[IX_TVAL])    tval_q    <= new_val;
      end
   end

   assign priv_o         = priv_q;
   assign rd_data        = old_val;
   assign rd_we          = csr_ok;
   assign redirect_valid = trap || mret_ok;
   assign redirect_pc    = trap ? tvec_q : epc_q;
endmodule

// File: rtl/csr_trap_unit_checker.sv
`timescale 1ns/1ps
module csr_trap_unit_checker #(
   parameter int XLEN  = 32,
   parameter int CNT_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             csr_req,
   input logic [1:0]       csr_op,
   input logic [11:0]      csr_addr,
   input logic             csr_src_zero,
   input logic             mret_req,
   input logic             exc_req,
   input logic [1:0]       priv_o,
   input logic             rd_we,
   input logic             redirect_valid,
   input logic [XLEN-1:0]  redirect_pc,
   input logic [XLEN-1:0]  tvec_q,
   input logic [XLEN-1:0]  epc_q,
   input logic [1:0]       st_mpp,
   input logic [CNT_W-1:0] cyc_full
);
   assert_user_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_req && !exc_req && priv_o == 2'b00 && csr_addr[9:8] == 2'b11)
         |-> (!rd_we && redirect_valid && redirect_pc == tvec_q));

   assert_ro_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_req && csr_addr[11:10] == 2'b11 && (csr_op == 2'b01 || !csr_src_zero))
         |-> !rd_we);

   assert_trap_to_machine_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req || (csr_req && !rd_we)) |=> (priv_o == 2'b11));

   assert_exc_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |-> (redirect_valid && redirect_pc == tvec_q));

   assert_mret_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mret_req && !exc_req && !csr_req && priv_o == 2'b11)
         |-> (redirect_valid && redirect_pc == epc_q));

   assert_mret_priv_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mret_req && !exc_req && !csr_req && priv_o == 2'b11)
         |=> (priv_o == $past(st_mpp)));

   assert_cycle_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cyc_full == $past(cyc_full) + 1'b1));

   assert_we_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rd_we |-> (csr_req && !exc_req && !redirect_valid));
endmodule

bind csr_trap_unit csr_trap_unit_checker #(.XLEN(XLEN), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_op(csr_op), .csr_addr(csr_addr),
   .csr_src_zero(csr_src_zero), .mret_req(mret_req), .exc_req(exc_req), .priv_o(priv_o),
   .rd_we(rd_we), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
   .tvec_q(tvec_q), .epc_q(epc_q), .st_mpp(st_mpp), .cyc_full(cyc_full));

// File: tb/csr_trap_unit_bench.sv
`timescale 1ns/1ps
module csr_trap_unit_bench;
   localparam int          XLEN    = 32;
   localparam int          CNT_W   = 64;
   localparam int          CAUSE_W = 5;
   localparam logic [63:0] C_INIT  = 64'h0000_0001_FFFF_FFF0;
   localparam logic [31:0] TV_RST  = 32'h0000_0100;
   localparam logic [31:0] TV_NEW  = 32'h8000_0100;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, csr_req, csr_src_zero, mret_req, exc_req;
   logic [1:0] csr_op;
   logic [11:0] csr_addr;
   logic [31:0] csr_src, instr_pc, instr_word;
   logic [CAUSE_W-1:0] exc_cause;
   logic [1:0] priv_o;
   logic [31:0] rd_data, redirect_pc;
   logic rd_we, redirect_valid;

   csr_trap_unit #(.XLEN(XLEN), .CNT_W(CNT_W), .CAUSE_W(CAUSE_W),
                   .CYCLE_INIT(C_INIT), .MTVEC_RESET(TV_RST)) u_csr_trap_unit (
      .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_op(csr_op), .csr_addr(csr_addr),
      .csr_src(csr_src), .csr_src_zero(csr_src_zero), .mret_req(mret_req),
      .exc_req(exc_req), .exc_cause(exc_cause), .instr_pc(instr_pc),
      .instr_word(instr_word), .priv_o(priv_o), .rd_data(rd_data), .rd_we(rd_we),
      .redirect_valid(redirect_valid), .redirect_pc(redirect_pc));

   // counter model from R11
   logic [63:0] edges;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) edges <= '0;
      else        edges <= edges + 1;
   end

   int checks = 0;
   int errors = 0;
   logic [31:0] r_data, r_pc;
   logic r_we, r_rv;
   logic [63:0] r_cnt;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      csr_req = 0; csr_op = 2'b00; csr_addr = '0; csr_src = '0; csr_src_zero = 0;
      mret_req = 0; exc_req = 0; exc_cause = '0;
   endtask

   task automatic step(input logic c, input logic [1:0] o, input logic [11:0] a,
                       input logic [31:0] s, input logic z, input logic m,
                       input logic e, input logic [CAUSE_W-1:0] ec);
      @(negedge clk);
      csr_req = c; csr_op = o; csr_addr = a; csr_src = s; csr_src_zero = z;
      mret_req = m; exc_req = e; exc_cause = ec;
      #2;
      r_data = rd_data; r_we = rd_we; r_rv = redirect_valid; r_pc = redirect_pc;
      r_cnt = C_INIT + edges;
      @(posedge clk);
      #1;
      idle();
   endtask

   task automatic acc(input logic [1:0] o, input logic [11:0] a, input logic [31:0] s, input logic z);
      step(1, o, a, s, z, 0, 0, '0);
   endtask

   task automatic rd(input logic [11:0] a);
      acc(2'b10, a, 32'h0, 1'b1);
   endtask

   // op, addr, src, src_zero, expected old value
   localparam int NV = 19;
   localparam logic [78:0] VEC [NV] = '{
      {2'b01, 12'h340, 32'hDEADBEEF, 1'b0, 32'h00000000},
      {2'b10, 12'h340, 32'h0000000F, 1'b0, 32'hDEADBEEF},
      {2'b11, 12'h340, 32'hFFFF0000, 1'b0, 32'hDEADBEEF},
      {2'b10, 12'h340, 32'h00000000, 1'b1, 32'h0000BEEF},
      {2'b01, 12'h305, 32'h80000103, 1'b0, 32'h00000100},
      {2'b10, 12'h305, 32'h00000000, 1'b1, 32'h80000100},
      {2'b01, 12'h300, 32'hFFFFFFFF, 1'b0, 32'h00000000},
      {2'b10, 12'h300, 32'h00000000, 1'b1, 32'h00001888},
      {2'b11, 12'h300, 32'h00000800, 1'b0, 32'h00001888},
      {2'b10, 12'h300, 32'h00000000, 1'b1, 32'h00000088},
      {2'b01, 12'h304, 32'h00000888, 1'b0, 32'h00000000},
      {2'b11, 12'h304, 32'h00000008, 1'b0, 32'h00000888},
      {2'b10, 12'h304, 32'h00000000, 1'b1, 32'h00000880},
      {2'b01, 12'h341, 32'h40000020, 1'b0, 32'h00000000},
      {2'b01, 12'h342, 32'h0000000B, 1'b0, 32'h00000000},
      {2'b01, 12'h343, 32'h12345678, 1'b0, 32'h00000000},
      {2'b10, 12'h342, 32'h00000000, 1'b1, 32'h0000000B},
      {2'b10, 12'h343, 32'h00000000, 1'b1, 32'h12345678},
      {2'b01, 12'h300, 32'h00000000, 1'b0, 32'h00000088}};

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 0; idle(); instr_pc = 32'h40000000; instr_word = 32'h00000013;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(posedge clk); #1;

      // R1 reset state
      chk("R1 priv", {30'h0, priv_o}, 32'h3);
      rd(12'h300); chk("R1 status", r_data, 32'h0);
      rd(12'h305); chk("R1 tvec", r_data, TV_RST);
      rd(12'h342); chk("R1 cause", r_data, 32'h0);
      rd(12'hC00); chk("R1 R11 count lo", r_data, r_cnt[31:0]);

      // R2 R3 R9 vector walk
      for (int i = 0; i < NV; i++) begin
         acc(VEC[i][78:77], VEC[i][76:65], VEC[i][64:33], VEC[i][32]);
         chk("R2 R3 R9 vec data", r_data, VEC[i][31:0]);
         chk("R2 vec we", {31'h0, r_we}, 32'h1);
      end

      // R11 counter halves across the carry
      rd(12'hC00); chk("R11 lo", r_data, r_cnt[31:0]);
      rd(12'hC80); chk("R11 hi", r_data, r_cnt[63:32]);

      // R5 write to the counter traps
      instr_pc = 32'h40000010; instr_word = 32'hC0001073;
      acc(2'b01, 12'hC00, 32'h0, 1'b0);
      chk("R5 ro we", {31'h0, r_we}, 32'h0);
      chk("R9 trap target", r_pc, TV_NEW);
      chk("R9 trap valid", {31'h0, r_rv}, 32'h1);
      rd(12'h342); chk("R7 cause", r_data, 32'h2);
      rd(12'h341); chk("R7 epc", r_data, 32'h40000010);
      rd(12'h343); chk("R7 tval", r_data, 32'hC0001073);
      rd(12'h300); chk("R8 status from M", r_data, 32'h00001800);
      rd(12'hC00); chk("R5 counter unchanged", r_data, r_cnt[31:0]);
      acc(2'b10, 12'hC80, 32'h1, 1'b0);
      chk("R5 set nonzero traps", {31'h0, r_we}, 32'h0);
      acc(2'b11, 12'hC80, 32'h1, 1'b1);
      chk("R5 zero-source read ok", {31'h0, r_we}, 32'h1);

      // R6 unimplemented address and reserved op
      acc(2'b01, 12'h7C0, 32'h5, 1'b0);
      chk("R6 no reg", {31'h0, r_we}, 32'h0);
      chk("R6 no reg trap", {31'h0, r_rv}, 32'h1);
      acc(2'b00, 12'h340, 32'hFFFFFFFF, 1'b0);
      chk("R6 op none", {31'h0, r_we}, 32'h0);
      rd(12'h340); chk("R7 scratch unchanged", r_data, 32'h0000BEEF);

      // R10 return to user
      acc(2'b01, 12'h300, 32'h00000088, 1'b0);
      acc(2'b01, 12'h341, 32'h40000030, 1'b0);
      step(0, 2'b00, 12'h0, 32'h0, 0, 1, 0, '0);
      chk("R10 mret target", r_pc, 32'h40000030);
      chk("R10 priv user", {30'h0, priv_o}, 32'h0);

      // R4 user mode
      rd(12'hC00); chk("R4 user counter read", {31'h0, r_we}, 32'h1);
      instr_pc = 32'h40000040; instr_word = 32'h34059073;
      acc(2'b01, 12'h340, 32'h11111111, 1'b0);
      chk("R4 user machine access", {31'h0, r_we}, 32'h0);
      chk("R4 trap target", r_pc, TV_NEW);
      chk("R8 back to M", {30'h0, priv_o}, 32'h3);
      rd(12'h300); chk("R8 status from U", r_data, 32'h00000080);
      rd(12'h340); chk("R7 user write dropped", r_data, 32'h0000BEEF);
      rd(12'h343); chk("R7 tval user", r_data, 32'h34059073);

      // R10 return attempted in user mode
      step(0, 2'b00, 12'h0, 32'h0, 0, 1, 0, '0);
      chk("R10 priv user again", {30'h0, priv_o}, 32'h0);
      instr_pc = 32'h40000044; instr_word = 32'h30200073;
      step(0, 2'b00, 12'h0, 32'h0, 0, 1, 0, '0);
      chk("R10 user mret traps", r_pc, TV_NEW);
      chk("R10 priv M", {30'h0, priv_o}, 32'h3);
      rd(12'h300); chk("R10 R8 status", r_data, 32'h00000080);
      rd(12'h341); chk("R10 epc", r_data, 32'h40000044);

      // R12 exception collides with a write
      acc(2'b01, 12'h300, 32'h00000008, 1'b0);
      instr_pc = 32'h40000050; instr_word = 32'h00000073;
      step(1, 2'b01, 12'h340, 32'hFFFFFFFF, 0, 0, 1, 5'd5);
      chk("R12 we low", {31'h0, r_we}, 32'h0);
      chk("R12 R9 exc target", r_pc, TV_NEW);
      rd(12'h340); chk("R12 scratch kept", r_data, 32'h0000BEEF);
      rd(12'h342); chk("R8 exc cause", r_data, 32'h5);
      rd(12'h300); chk("R8 exc status", r_data, 32'h00001880);

      // R10 return in M with MPP=3
      step(0, 2'b00, 12'h0, 32'h0, 0, 1, 0, '0);
      chk("R10 mret M target", r_pc, 32'h40000050);
      chk("R10 stays M", {30'h0, priv_o}, 32'h3);
      rd(12'h300); chk("R10 status after", r_data, 32'h00000088);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule